// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver with Sticky Error Flags

This block receives asynchronous serial frames on a single line. It runs from the system clock, gated by a one-cycle enable that pulses at sixteen times the bit rate. The serial input first passes through a two-flop synchroniser. While idle, the receiver waits for the line to go low on an enable tick. It then checks the start bit at its middle and samples each later bit on the sixteenth tick after the previous sample, which is mid-bit. A frame has eight data bits sent least significant bit first, an optional parity bit (even or odd) and one stop bit.

A completed byte goes into a single holding register, and a full flag is raised. A read strobe empties the register. Overrun, parity and framing errors each have a sticky flag that stays set until its own clear strobe. While the line is held low (a break), the receiver keeps producing frames. A cleared framing flag therefore comes back for as long as the break lasts. Dropping the receive enable stops reception but leaves the error flags as they are.

Top module: `uart_rx_sticky`

## Requirements
- R1: After reset, full_o, ovr_o, per_o and fer_o are 0 and data_o is 0.
- R2: A frame with a high stop bit and no parity leaves its eight data bits in data_o, with the first serial data bit at bit 0, and sets full_o.
- R3: A one-cycle pulse on rd_i clears full_o when no frame completes in that cycle.
- R4: A start bit that reads high at its mid sample (the 8th tick after detection) is discarded. No frame is produced and data_o is unchanged.
- R5: With par_en_i=1, one parity bit follows the data bits. For even parity (par_odd_i=0) the expected bit is the XOR of the data bits; for odd parity (par_odd_i=1) it is the inverse of that XOR. A mismatch sets per_o, and the byte is still delivered.
- R6: A low stop bit at its mid sample sets fer_o, and the byte is still delivered.
- R7: A frame that completes while full_o=1 and rd_i=0 sets ovr_o and leaves the previous byte in data_o.
- R8: Each error flag stays set until its own clear strobe (ovr_clr_i, per_clr_i, fer_clr_i). A strobe leaves the other flags unchanged.
- R9: A break (line held low) sets fer_o, and with odd parity also sets per_o. Reception goes on while the line stays low, so fer_o is set again after it has been cleared.
- R10: While rx_en_i=0 no frame is received, and the error flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial input, high when idle |
| rx_en_i | input | 1 | Receive enable |
| tick_i | input | 1 | Enable pulse at 16x the bit rate |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| data_o | output | 8 | Received byte |
| full_o | output | 1 | Holding register holds an unread byte |
| rd_i | input | 1 | Read strobe, empties the holding register |
| ovr_o | output | 1 | Sticky overrun flag |
| per_o | output | 1 | Sticky parity error flag |
| fer_o | output | 1 | Sticky framing error flag |
| ovr_clr_i | input | 1 | Clears ovr_o |
| per_clr_i | input | 1 | Clears per_o |
| fer_clr_i | input | 1 | Clears fer_o |

## Verification
The hardest case to reach is a framing flag that comes back after being cleared. It needs the line to stay low across two whole frames, with the clear strobe landing between the first frame's stop sample and the second. The bench holds the line low for about twenty-two bit times. It clears the flags once the first frame has finished, then checks that the flag is 0 right after the clear and 1 again after the next frame. A bad stop bit also needs care: it is held low only long enough to cover its mid sample. The restart that follows then sees a high line at mid-start and is dropped as noise, rather than turning into a phantom frame.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rx_state_e;

  localparam int NFLAG   = 3;
  localparam int FLG_FER = 0;
  localparam int FLG_PER = 1;
  localparam int FLG_OVR = 2;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  // reset to idle-high so no false start after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              per_err_o,
  output logic              fer_err_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] LAST    = IDX_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              par_q, par_en_q, par_odd_q;
  logic              bit_mid;

  assign bit_mid = tick_i && (cnt_q == FULL_M1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      shift_q   <= '0;
      par_q     <= 1'b0;
      par_en_q  <= 1'b0;
      par_odd_q <= 1'b0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          // low level on a tick: start edge, or a break still in progress
          if (!rx_i) begin
            state_q   <= ST_START;
            par_en_q  <= par_en_i;
            par_odd_q <= par_odd_i;
          end
        end
        ST_START: if (cnt_q == HALF_M1) begin
          cnt_q   <= '0;
          idx_q   <= '0;
          state_q <= rx_i ? ST_IDLE : ST_DATA;
        end
        ST_DATA: if (bit_mid) begin
          shift_q <= {rx_i, shift_q[DATA_W-1:1]};
          idx_q   <= idx_q + 1'b1;
          if (idx_q == LAST) state_q <= par_en_q ? ST_PAR : ST_STOP;
        end
        ST_PAR: if (bit_mid) begin
          par_q   <= rx_i;
          state_q <= ST_STOP;
        end
        ST_STOP: if (bit_mid) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o    = en_i && bit_mid && (state_q == ST_STOP);
  assign data_o    = shift_q;
  assign fer_err_o = !rx_i;
  assign per_err_o = par_en_q && (par_q != ((^shift_q) ^ par_odd_q));
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              per_err_i,
  input  logic              fer_err_i,
  input  logic              rd_i,
  input  logic [NFLAG-1:0]  clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic [NFLAG-1:0]  flag_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              load;
  logic [NFLAG-1:0]  set_v;

  assign load = done_i && (!full_q || rd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (load) begin
      full_q <= 1'b1;
      data_q <= data_i;
    end else if (rd_i) begin
      full_q <= 1'b0;
    end
  end

  always_comb begin
    set_v          = '0;
    set_v[FLG_OVR] = done_i && full_q && !rd_i;
    set_v[FLG_PER] = done_i && per_err_i;
    set_v[FLG_FER] = done_i && fer_err_i;
  end

  // set wins over a clear in the same cycle
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       f_q <= 1'b0;
      else if (set_v[g]) f_q <= 1'b1;
      else if (clr_i[g]) f_q <= 1'b0;
    end
    assign flag_o[g] = f_q;
  end

  assign data_o = data_q;
  assign full_o = full_q;
endmodule

// File: rtl/uart_rx_sticky.sv
module uart_rx_sticky
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              rx_en_i,
  input  logic              tick_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  input  logic              rd_i,
  output logic              ovr_o,
  output logic              per_o,
  output logic              fer_o,
  input  logic              ovr_clr_i,
  input  logic              per_clr_i,
  input  logic              fer_clr_i
);
  logic              rx_s;
  logic              frame_done;
  logic [DATA_W-1:0] frame_data;
  logic              frame_per, frame_fer;
  logic [NFLAG-1:0]  clr_v, flag_v;

  uart_rx_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i, .rst_ni, .d_i(rx_i), .q_o(rx_s)
  );

  uart_rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
    .clk_i, .rst_ni,
    .en_i(rx_en_i), .tick_i, .rx_i(rx_s),
    .par_en_i, .par_odd_i,
    .done_o(frame_done), .data_o(frame_data),
    .per_err_o(frame_per), .fer_err_o(frame_fer)
  );

  always_comb begin
    clr_v          = '0;
    clr_v[FLG_OVR] = ovr_clr_i;
    clr_v[FLG_PER] = per_clr_i;
    clr_v[FLG_FER] = fer_clr_i;
  end

  uart_rx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk_i, .rst_ni,
    .done_i(frame_done), .data_i(frame_data),
    .per_err_i(frame_per), .fer_err_i(frame_fer),
    .rd_i, .clr_i(clr_v),
    .data_o, .full_o, .flag_o(flag_v)
  );

  assign ovr_o = flag_v[FLG_OVR];
  assign per_o = flag_v[FLG_PER];
  assign fer_o = flag_v[FLG_FER];
endmodule

// File: rtl/uart_rx_sticky_chk.sv
module uart_rx_sticky_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_en_i,
  input logic              rd_i,
  input logic              ovr_clr_i,
  input logic              per_clr_i,
  input logic              fer_clr_i,
  input logic              frame_done,
  input logic              frame_fer,
  input logic [DATA_W-1:0] data_o,
  input logic              full_o,
  input logic              ovr_o,
  input logic              per_o,
  input logic              fer_o
);
  // R2
  full_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_o ##1 full_o |-> $past(frame_done));

  // R3
  read_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !frame_done) |=> !full_o);

  // R6
  fer_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && frame_fer) |=> fer_o);

  // R7
  overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && full_o && !rd_i) |=> (ovr_o && $stable(data_o)));

  // R8
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !ovr_clr_i) |=> ovr_o);

  // R8
  per_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_o && !per_clr_i) |=> per_o);

  // R8
  fer_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fer_o && !fer_clr_i) |=> fer_o);

  // R10
  disabled_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_i && !full_o) |=> !full_o);
endmodule

bind uart_rx_sticky uart_rx_sticky_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_en_i(rx_en_i), .rd_i(rd_i),
  .ovr_clr_i(ovr_clr_i), .per_clr_i(per_clr_i), .fer_clr_i(fer_clr_i),
  .frame_done(frame_done), .frame_fer(frame_fer),
  .data_o(data_o), .full_o(full_o),
  .ovr_o(ovr_o), .per_o(per_o), .fer_o(fer_o)
);

// File: tb/uart_rx_sticky_tb.sv
`timescale 1ns/1ps
module uart_rx_sticky_tb;
  localparam int BITCLK = 64; // 16 ticks x 4 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1, rx_en = 1'b0, tick = 1'b0;
  logic       par_en = 1'b0, par_odd = 1'b0;
  logic       rd = 1'b0, ovr_clr = 1'b0, per_clr = 1'b0, fer_clr = 1'b0;
  logic [7:0] data;
  logic       full, ovr, per, fer;
  logic [1:0] div = '0;
  int         errors = 0, checks = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    div  <= div + 2'd1;
    tick <= (div == 2'd3);
  end

  uart_rx_sticky u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .rx_en_i(rx_en), .tick_i(tick),
    .par_en_i(par_en), .par_odd_i(par_odd),
    .data_o(data), .full_o(full), .rd_i(rd),
    .ovr_o(ovr), .per_o(per), .fer_o(fer),
    .ovr_clr_i(ovr_clr), .per_clr_i(per_clr), .fer_clr_i(fer_clr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hold_bit(input logic b, input int clocks);
    rx = b;
    repeat (clocks) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic pbit, input logic stop_ok);
    hold_bit(1'b0, BITCLK);
    for (int i = 0; i < 8; i++) hold_bit(d[i], BITCLK);
    if (par_en) hold_bit(pbit, BITCLK);
    if (stop_ok) hold_bit(1'b1, BITCLK);
    else begin
      hold_bit(1'b0, 44); // covers the mid sample only
      hold_bit(1'b1, BITCLK);
    end
    hold_bit(1'b1, BITCLK);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset;
    chk(full == 0 && ovr == 0 && per == 0 && fer == 0, "R1 flags", {full, ovr, per, fer}, 0);
    chk(data == 8'h00, "R1 data", data, 0);
  endtask

  task automatic t_basic;
    send(8'hA5, 1'b0, 1'b1);
    chk(full == 1, "R2 full", full, 1);
    chk(data == 8'hA5, "R2 data", data, 8'hA5);
    pulse(rd);
    chk(full == 0, "R3 read clears", full, 0);
    send(8'h3C, 1'b0, 1'b1);
    chk(data == 8'h3C && full == 1, "R2 second data", data, 8'h3C);
    pulse(rd);
  endtask

  task automatic t_noise;
    hold_bit(1'b0, 12);
    hold_bit(1'b1, BITCLK * 12);
    chk(full == 0, "R4 no frame", full, 0);
    chk(data == 8'h3C, "R4 data kept", data, 8'h3C);
  endtask

  task automatic t_parity;
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h07, 1'b1, 1'b1);
    chk(per == 0 && data == 8'h07, "R5 even ok", {per, data}, 8'h07);
    pulse(rd);
    send(8'h06, 1'b1, 1'b1);
    chk(per == 1, "R5 even mismatch", per, 1);
    chk(data == 8'h06, "R5 data delivered", data, 8'h06);
    pulse(rd);
    pulse(per_clr);
    chk(per == 0 && fer == 0 && ovr == 0, "R8 per clear only", {ovr, per, fer}, 0);
    par_en = 1'b0;
  endtask

  task automatic t_framing;
    send(8'h81, 1'b0, 1'b0);
    chk(fer == 1, "R6 fer set", fer, 1);
    chk(data == 8'h81, "R6 data delivered", data, 8'h81);
    pulse(rd);
    repeat (50) @(negedge clk);
    chk(fer == 1, "R8 fer holds", fer, 1);
    pulse(ovr_clr);
    chk(fer == 1, "R8 other strobe", fer, 1);
    pulse(fer_clr);
    chk(fer == 0, "R8 fer cleared", fer, 0);
  endtask

  task automatic t_overrun;
    send(8'h11, 1'b0, 1'b1);
    send(8'h22, 1'b0, 1'b1);
    chk(ovr == 1, "R7 ovr set", ovr, 1);
    chk(data == 8'h11, "R7 data kept", data, 8'h11);
    pulse(ovr_clr);
    chk(ovr == 0 && full == 1, "R8 ovr clear", {ovr, full}, 1);
    pulse(rd);
  endtask

  task automatic t_break;
    par_en = 1'b1; par_odd = 1'b1;
    hold_bit(1'b0, BITCLK * 11);
    chk(fer == 1, "R9 break fer", fer, 1);
    chk(per == 1, "R9 break per", per, 1);
    chk(data == 8'h00, "R9 break data", data, 0);
    fer_clr = 1'b1; per_clr = 1'b1; @(negedge clk);
    fer_clr = 1'b0; per_clr = 1'b0;
    chk(fer == 0, "R9 fer cleared in break", fer, 0);
    hold_bit(1'b0, BITCLK * 11);
    chk(fer == 1, "R9 fer returns", fer, 1);
    hold_bit(1'b1, BITCLK * 2);
    par_en = 1'b0; par_odd = 1'b0;
  endtask

  task automatic t_disable;
    rx_en = 1'b0;
    repeat (20) @(negedge clk);
    chk(fer == 1 && per == 1 && ovr == 1, "R10 flags kept", {ovr, per, fer}, 3'b111);
    pulse(rd);
    send(8'h5A, 1'b0, 1'b1);
    chk(full == 0, "R10 no reception", full, 0);
    rx_en = 1'b1;
    ovr_clr = 1'b1; per_clr = 1'b1; fer_clr = 1'b1; @(negedge clk);
    ovr_clr = 1'b0; per_clr = 1'b0; fer_clr = 1'b0;
    hold_bit(1'b1, BITCLK);
    send(8'h96, 1'b0, 1'b1);
    chk(full == 1 && data == 8'h96, "R2 after re-enable", data, 8'h96);
    chk(ovr == 0 && per == 0 && fer == 0, "R8 all cleared", {ovr, per, fer}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    rx_en = 1'b1;
    hold_bit(1'b1, BITCLK);
    t_basic;
    t_noise;
    t_parity;
    t_framing;
    t_overrun;
    t_break;
    t_disable;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule